// File: doc/BRIEF.md
# Asynchronous Frame Transmitter

This block turns bytes into asynchronous serial frames on one output line. The frame shape comes from a small mode register. That register selects 7 or 8 data bits, optional even or odd parity, one or two stop bits, and a multiprocessor mode. In multiprocessor mode a flag bit, supplied with each byte, is sent in the slot that would otherwise hold parity.

Bit timing comes from an external baud tick, a one-cycle enable pulse. Every bit of the frame lasts from one tick to the next. A single holding register accepts a byte through a valid/ready handshake. Because of it, software can queue the next byte while the current frame is still on the line. When the holding register is full at the end of a frame, the next frame starts with no idle gap.

The block reports `busy` while a frame is in progress. It reports `tx_end` once the line has gone idle with nothing pending.

Top module: `async_frame_tx`

## Requirements
- R1: The mode register holds five fields: bit 0 selects a 7-bit character, bit 1 enables parity, bit 2 selects odd parity, bit 3 selects two stop bits, and bit 4 enables multiprocessor mode. A write with `mode_we` high stores `mode_wdata`. After reset all fields are 0, which gives 8 data bits, no parity and 1 stop bit.
- R2: The line rests at 1 when idle. Each frame begins with one start bit at 0. The line changes only in the cycle after a baud tick, so each bit lasts exactly one tick period.
- R3: With bit 0 clear, the 8 data bits follow the start bit, least significant bit first.
- R4: With bit 0 set, only data bits 0 to 6 are sent, least significant bit first. Data bit 7 never reaches the line.
- R5: With parity on and multiprocessor mode off, one parity bit follows the data. The parity bit makes the number of ones among the sent data bits and the parity bit even when bit 2 is 0, and odd when bit 2 is 1.
- R6: One stop bit at 1 ends the frame, or two stop bits when bit 3 is set.
- R7: With multiprocessor mode on, the `tx_mpb` value captured with the byte is sent right after the data bits. No parity bit is sent, whatever bits 1 and 2 hold.
- R8: The mode is captured when a frame starts. A write during a frame does not change that frame. A write made before the start, even with data already pending, applies to the next frame.
- R9: `tx_ready` is 1 exactly when the holding register is empty. A byte is accepted in a cycle where `tx_valid` and `tx_ready` are both 1. The holding register empties at the tick that starts that byte's frame.
- R10: `tx_end` is 1 after reset. It clears when a frame starts and sets at the tick that ends the last stop bit when no byte is pending. If a byte is pending at that tick, its start bit follows at once. `busy` is 1 from the start bit through the last stop bit and is never 1 together with `tx_end`.
- R11: A frame starts only on a baud tick while a byte is pending. Without ticks the line stays idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| baud_tick | input | 1 | One-cycle pulse marking each bit boundary |
| mode_we | input | 1 | Mode register write strobe |
| mode_wdata | input | 5 | Mode register write value |
| tx_valid | input | 1 | Byte offered for transmission |
| tx_data | input | 8 | Byte to transmit |
| tx_mpb | input | 1 | Multiprocessor flag sent with this byte |
| tx_ready | output | 1 | Holding register empty, byte can be accepted |
| txd | output | 1 | Serial line |
| busy | output | 1 | Frame in progress |
| tx_end | output | 1 | Line idle with nothing pending |

## Verification
The assertions check on every cycle that:
- the sequencer and the line move only on baud ticks;
- the captured mode stays frozen for the whole frame;
- a pending byte is held unchanged until it is taken;
- the line never goes low outside a frame;
- `busy` and `tx_end` never overlap.

Only the bench's scenarios can show the bit order and the parity value, and that the MSB is dropped in 7-bit mode. The same holds for the multiprocessor flag's slot and the stop-bit count. To cover these, the bench sweeps all 32 mode values over several data patterns. Separate scenarios cover these remaining cases:
- a mode write during a frame;
- a mode write made with a byte pending;
- back-to-back frames;
- a pending byte with no ticks.

// File: rtl/async_tx_pkg.sv
// Shared types for the asynchronous frame transmitter.
// Assumes nothing beyond IEEE 1800-2017 packed structs and enums.
package async_tx_pkg;

    // Mode register layout, MSB first: bit4 mp_en ... bit0 short7.
    typedef struct packed {
        logic mp_en;
        logic two_stop;
        logic par_odd;
        logic par_en;
        logic short7;
    } tx_mode_t;

    localparam int MODE_W = $bits(tx_mode_t);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_EXTRA,
        ST_STOP1,
        ST_STOP2
    } tx_state_e;

endpackage

// File: rtl/tx_mode_reg.sv
// Mode register: stores the frame-format word on each write strobe.
// Assumes writes may arrive at any time; the sequencer decides when
// the stored value is used.
module tx_mode_reg
    import async_tx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_we,
    input  logic [MODE_W-1:0] mode_wdata,
    output tx_mode_t          mode_q
);

    // Capture the mode word on a write; clear all fields on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= '0;
        end else if (mode_we) begin
            mode_q <= tx_mode_t'(mode_wdata);
        end
    end

endmodule

// File: rtl/tx_hold.sv
// Holding register: a one-entry buffer between the valid/ready
// handshake and the frame sequencer.
// Assumes take is only raised while full_q is set.
module tx_hold #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_mpb,
    input  logic              take,
    output logic              in_ready,
    output logic              full_q,
    output logic [DATA_W-1:0] data_q,
    output logic              mpb_q
);

    logic accept;

    // Ready whenever empty; accept on a completed handshake.
    always_comb begin
        in_ready = !full_q;
        accept   = in_valid && in_ready;
    end

    // Fill on accept, empty when the sequencer takes the byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            full_q <= 1'b0;
            data_q <= '0;
            mpb_q  <= 1'b0;
        end else if (accept) begin
            full_q <= 1'b1;
            data_q <= in_data;
            mpb_q  <= in_mpb;
        end else if (take) begin
            full_q <= 1'b0;
        end
    end

    // A pending byte is kept intact until the sequencer takes it.
    assert_hold_keeps_byte_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (full_q && !take) |=> (full_q && $stable(data_q) && $stable(mpb_q)));

    // A completed handshake always leaves the buffer full.
    assert_accept_fills_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> full_q);

endmodule

// File: rtl/tx_extra_bit.sv
// Extra-slot bit: computes the bit placed after the data field.
// In multiprocessor mode it is the captured flag; otherwise it is the
// parity over the sent data bits (the MSB is masked in short mode).
// Assumes DATA_W >= 2.
module tx_extra_bit
    import async_tx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  tx_mode_t          cfg,
    input  logic [DATA_W-1:0] data,
    input  logic              mpb,
    output logic              has_extra,
    output logic              extra_bit
);

    logic [DATA_W-1:0] sent_mask;
    logic              parity_bit;

    // Build the mask of transmitted data bits; only the MSB depends on mode.
    for (genvar g = 0; g < DATA_W; g++) begin : g_mask
        if (g == DATA_W - 1) begin : g_top
            assign sent_mask[g] = !cfg.short7;
        end else begin : g_low
            assign sent_mask[g] = 1'b1;
        end
    end

    // Select parity or multiprocessor flag for the extra slot.
    always_comb begin
        parity_bit = (^(data & sent_mask)) ^ cfg.par_odd;
        has_extra  = cfg.mp_en || cfg.par_en;
        extra_bit  = cfg.mp_en ? mpb : parity_bit;
    end

endmodule

// File: rtl/tx_sequencer.sv
// Frame sequencer: walks start, data, extra, and stop slots one baud
// tick at a time, capturing the byte and the mode at each frame start.
// Assumes baud_tick is a single-cycle pulse and that the holding
// register presents a stable byte while hold_full is set.
module tx_sequencer
    import async_tx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              baud_tick,
    input  tx_mode_t          mode_q,
    input  logic              hold_full,
    input  logic [DATA_W-1:0] hold_data,
    input  logic              hold_mpb,
    output logic              take,
    output logic              txd,
    output logic              busy,
    output logic              tx_end
);

    localparam int IDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;

    tx_state_e         state_q, state_d;
    logic [IDX_W-1:0]  idx_q, idx_d;
    logic [IDX_W-1:0]  last_idx;
    tx_mode_t          cfg_q;
    logic [DATA_W-1:0] frame_q;
    logic              mpb_q;
    logic              has_extra;
    logic              extra_bit;
    logic              frame_done;
    logic              end_set;

    tx_extra_bit #(.DATA_W(DATA_W)) u_extra (
        .cfg       (cfg_q),
        .data      (frame_q),
        .mpb       (mpb_q),
        .has_extra (has_extra),
        .extra_bit (extra_bit)
    );

    // Decide the next slot, frame completion and byte take on each tick.
    always_comb begin
        state_d    = state_q;
        idx_d      = idx_q;
        last_idx   = cfg_q.short7 ? IDX_W'(DATA_W - 2) : IDX_W'(DATA_W - 1);
        frame_done = (state_q == ST_STOP2) ||
                     (state_q == ST_STOP1 && !cfg_q.two_stop);
        take       = baud_tick && hold_full && (state_q == ST_IDLE || frame_done);
        end_set    = baud_tick && frame_done && !hold_full;
        if (baud_tick) begin
            unique case (state_q)
                ST_IDLE:  if (hold_full) state_d = ST_START;
                ST_START: begin
                    state_d = ST_DATA;
                    idx_d   = '0;
                end
                ST_DATA: begin
                    if (idx_q == last_idx) begin
                        state_d = has_extra ? ST_EXTRA : ST_STOP1;
                    end else begin
                        idx_d = idx_q + 1'b1;
                    end
                end
                ST_EXTRA: state_d = ST_STOP1;
                ST_STOP1: begin
                    if (cfg_q.two_stop)   state_d = ST_STOP2;
                    else if (hold_full)   state_d = ST_START;
                    else                  state_d = ST_IDLE;
                end
                ST_STOP2: state_d = hold_full ? ST_START : ST_IDLE;
                default:  state_d = ST_IDLE;
            endcase
        end
    end

    // Advance slot state and capture byte plus mode at frame start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
            cfg_q   <= '0;
            frame_q <= '0;
            mpb_q   <= 1'b0;
            tx_end  <= 1'b1;
        end else begin
            state_q <= state_d;
            idx_q   <= idx_d;
            if (take) begin
                cfg_q   <= mode_q;
                frame_q <= hold_data;
                mpb_q   <= hold_mpb;
                tx_end  <= 1'b0;
            end else if (end_set) begin
                tx_end  <= 1'b1;
            end
        end
    end

    // Drive the line level for the current slot.
    always_comb begin
        busy = (state_q != ST_IDLE);
        unique case (state_q)
            ST_START: txd = 1'b0;
            ST_DATA:  txd = frame_q[idx_q];
            ST_EXTRA: txd = extra_bit;
            default:  txd = 1'b1;
        endcase
    end

    // Slot state moves only on a baud tick.
    assert_state_on_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !baud_tick |=> $stable(state_q));

    // Captured mode is frozen while a frame runs and no new one starts.
    assert_mode_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !take) |=> $stable(cfg_q));

    // Busy and transmit-end never overlap.
    assert_busy_end_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && tx_end));

endmodule

// File: rtl/async_frame_tx.sv
// Asynchronous frame transmitter top: mode register, one-byte holding
// register and frame sequencer.
// Assumes an external divider supplies baud_tick as a one-cycle pulse
// per bit period.
module async_frame_tx
    import async_tx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              baud_tick,
    input  logic              mode_we,
    input  logic [MODE_W-1:0] mode_wdata,
    input  logic              tx_valid,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              tx_mpb,
    output logic              tx_ready,
    output logic              txd,
    output logic              busy,
    output logic              tx_end
);

    tx_mode_t          mode_q;
    logic              hold_full;
    logic [DATA_W-1:0] hold_data;
    logic              hold_mpb;
    logic              take;

    tx_mode_reg u_mode (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode_we    (mode_we),
        .mode_wdata (mode_wdata),
        .mode_q     (mode_q)
    );

    tx_hold #(.DATA_W(DATA_W)) u_hold (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (tx_valid),
        .in_data  (tx_data),
        .in_mpb   (tx_mpb),
        .take     (take),
        .in_ready (tx_ready),
        .full_q   (hold_full),
        .data_q   (hold_data),
        .mpb_q    (hold_mpb)
    );

    tx_sequencer #(.DATA_W(DATA_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .baud_tick (baud_tick),
        .mode_q    (mode_q),
        .hold_full (hold_full),
        .hold_data (hold_data),
        .hold_mpb  (hold_mpb),
        .take      (take),
        .txd       (txd),
        .busy      (busy),
        .tx_end    (tx_end)
    );

    // The line is low only inside a frame.
    assert_idle_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !txd |-> busy);

    // A frame only begins right after a baud tick.
    assert_start_on_tick_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(baud_tick));

endmodule

// File: tb/sim_async_frame_tx.sv
// Bench: sweeps every mode value over several bytes and checks each
// bit of each frame, plus mode-timing, back-to-back and no-tick cases.
module sim_async_frame_tx;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       baud_tick = 1'b0;
    logic       mode_we = 1'b0;
    logic [4:0] mode_wdata = '0;
    logic       tx_valid = 1'b0;
    logic [7:0] tx_data = '0;
    logic       tx_mpb = 1'b0;
    logic       tx_ready, txd, busy, tx_end;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #5 clk = !clk;

    async_frame_tx u0 (
        .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick),
        .mode_we(mode_we), .mode_wdata(mode_wdata),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_mpb(tx_mpb),
        .tx_ready(tx_ready), .txd(txd), .busy(busy), .tx_end(tx_end)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    // One tick pulse; outputs sampled at the following falling edge.
    task automatic do_tick();
        @(negedge clk) baud_tick = 1'b1;
        @(negedge clk) baud_tick = 1'b0;
    endtask

    task automatic write_mode(input logic [4:0] m);
        @(negedge clk) begin mode_we = 1'b1; mode_wdata = m; end
        @(negedge clk) mode_we = 1'b0;
    endtask

    task automatic load(input logic [7:0] d, input logic f);
        @(negedge clk) begin tx_valid = 1'b1; tx_data = d; tx_mpb = f; end
        @(negedge clk) tx_valid = 1'b0;
    endtask

    // Check the frame after its starting tick; optionally the idle tail.
    task automatic check_frame(input logic [4:0] m, input logic [7:0] d,
                               input logic f, input bit expect_idle);
        int   nbits;
        logic par;
        nbits = m[0] ? 7 : 8;
        chk("R2 start bit", txd, 1'b0);
        chk("R10 busy at start", busy, 1'b1);
        chk("R10 end cleared", tx_end, 1'b0);
        par = m[2];
        for (int i = 0; i < nbits; i++) begin
            do_tick();
            chk(m[0] ? "R4 data bit" : "R3 data bit", txd, d[i]);
            par = par ^ d[i];
        end
        if (m[4]) begin
            do_tick();
            chk("R7 mp flag slot", txd, f);
        end else if (m[1]) begin
            do_tick();
            chk("R5 parity", txd, par);
        end
        do_tick();
        chk("R6 stop1", txd, 1'b1);
        if (m[3]) begin
            do_tick();
            chk("R6 stop2", txd, 1'b1);
        end
        chk("R10 busy in stop", busy, 1'b1);
        if (expect_idle) begin
            do_tick();
            chk("R10 idle busy", busy, 1'b0);
            chk("R10 end set", tx_end, 1'b1);
            chk("R2 idle high", txd, 1'b1);
        end
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin : main
        logic [7:0] pats [6];
        pats = '{8'h00, 8'hFF, 8'hA5, 8'h5A, 8'h01, 8'h80};
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R10 reset end", tx_end, 1'b1);
        chk("R10 reset busy", busy, 1'b0);
        chk("R2 reset idle", txd, 1'b1);
        chk("R9 reset ready", tx_ready, 1'b1);

        // R1: reset mode gives 8N1 without any write.
        load(8'hC3, 1'b1);
        chk("R9 full", tx_ready, 1'b0);
        // R11: no tick, no frame.
        repeat (5) @(negedge clk);
        chk("R11 no tick idle", txd, 1'b1);
        chk("R11 no tick busy", busy, 1'b0);
        do_tick();
        chk("R9 emptied at start", tx_ready, 1'b1);
        check_frame(5'h00, 8'hC3, 1'b1, 1'b1);

        // R1 sweep over all mode values and patterns.
        for (int m = 0; m < 32; m++) begin
            for (int p = 0; p < 6; p++) begin
                write_mode(5'(m));
                load(pats[p], pats[p][0] ^ 1'b1);
                do_tick();
                check_frame(5'(m), pats[p], pats[p][0] ^ 1'b1, 1'b1);
            end
        end

        // R8: write during a frame does not affect it, applies to the next.
        write_mode(5'h00);
        load(8'h81, 1'b0);
        do_tick();
        write_mode(5'h1F);
        check_frame(5'h00, 8'h81, 1'b0, 1'b1);
        load(8'h81, 1'b0);
        do_tick();
        check_frame(5'h1F, 8'h81, 1'b0, 1'b1);

        // R8: write after load but before start applies.
        write_mode(5'h00);
        load(8'h6E, 1'b0);
        write_mode(5'h0E);
        do_tick();
        check_frame(5'h0E, 8'h6E, 1'b0, 1'b1);

        // R10: back-to-back frames with no idle gap.
        write_mode(5'h00);
        load(8'h35, 1'b0);
        do_tick();
        chk("R9 ready after take", tx_ready, 1'b1);
        load(8'hCA, 1'b0);
        chk("R9 ready low when pending", tx_ready, 1'b0);
        check_frame(5'h00, 8'h35, 1'b0, 1'b0);
        do_tick();
        chk("R10 no gap end", tx_end, 1'b0);
        check_frame(5'h00, 8'hCA, 1'b0, 1'b1);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule